// File: doc/BRIEF.md
# Serial DAC host write controller

This block sits on the host side of a quad 12-bit serial-input voltage-output converter. It takes one request at a time over a valid/ready handshake and turns it into pin activity at the converter. A write request carries a channel number, a 12-bit code and two strobe flags. The block shifts a 16-bit word out on the chip-select, serial-clock and serial-data pins. It can then pulse the load-register strobe, which latches the word into the selected channel's input register, and the load-all strobe, which moves every input register to the outputs at the same moment. A clear request drives the converter's reset pin low after it sets the reset-level pin to zero-scale or mid-scale.

Each pin edge is spaced by a count of system-clock cycles taken from a parameter. The integrator rounds each converter minimum time up to whole cycles for the clock in use. After each sequence the block can wait a fixed number of settle cycles before it accepts the next request.

Top module: `dac_host_writer`

## Requirements
- R1: A write shifts exactly 16 bits, most significant first, each one sampled by the converter on a rising serial-clock edge while chip select is low. Bits 15:14 carry the channel, bits 13:12 are driven 0, and bits 11:0 carry the code.
- R2: Serial data changes only in the cycle where the serial clock falls. Every low phase lasts at least max(T_CL, T_DS) cycles and every high phase at least max(T_CH, T_DH) cycles.
- R3: Chip select falls at least T_CSS cycles before the first rising clock edge. It rises only while the clock is high, and no sooner than T_CSH cycles after the last rising edge.
- R4: The load-register strobe stays high for as long as chip select is low, and it has been high for at least T_LD1 cycles at every rising clock edge.
- R5: When req_load_reg is 1, one load-register low pulse follows the frame. It falls at least T_LD2 cycles after the last rising edge, with the clock high and chip select high, and lasts at least T_LDRW cycles. When req_load_reg is 0, no pulse occurs.
- R6: When req_load_all is 1, one load-all low pulse of at least T_LDDW cycles follows the frame. It starts only while chip select and the load-register strobe are both high. When req_load_all is 0, no pulse occurs.
- R7: A request with req_clear = 1 shifts no frame. It sets the reset-level pin to req_mid (1 = mid-scale, 0 = zero-scale), holds that level for at least T_RSSH cycles before the reset pin falls, and then holds the reset pin low for at least T_RSTW cycles. The reset-level pin does not change while the reset pin is low.
- R8: req_ready is 0 from the cycle after a request is accepted until the sequence is complete. After the last pin edge of a sequence, exactly T_SETTLE further cycles pass before req_ready returns to 1. In those cycles the pins sit at idle levels.
- R9: While req_ready is 1, chip select, serial clock, both load strobes and the reset pin are all high. A system reset, even during a frame, returns the block to this state with the reset-level pin at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_clear | input | 1 | 1 = clear request, 0 = write request |
| req_mid | input | 1 | Reset level for a clear: 1 mid-scale, 0 zero-scale |
| req_chan | input | CHAN_W | Target channel of a write |
| req_code | input | CODE_W | Converter code of a write |
| req_load_reg | input | 1 | Pulse the load-register strobe after the frame |
| req_load_all | input | 1 | Pulse the load-all strobe after the frame |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_sclk | output | 1 | Converter serial clock |
| dac_sdi | output | 1 | Converter serial data |
| dac_ldreg_n | output | 1 | Load selected input register, active low |
| dac_ldall_n | output | 1 | Load all output registers, active low |
| dac_rst_n | output | 1 | Converter reset, active low |
| dac_rstsel | output | 1 | Converter reset level select |

## Verification
The assertions assume that every timing parameter is at least 1 and stays below 255, the point where the checker's run-length counters saturate. They also assume that request fields only matter in the cycle the handshake completes. The properties look only at the converter pins and the ready flag, so they do not depend on how the host drives a request. The bench offers each request only when it sees req_ready high, changes inputs half a cycle away from the active edge, and drops req_valid right after acceptance. It applies a system reset in the middle of a frame only on purpose, to exercise R9.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SH_LO,
        ST_SH_HI,
        ST_LDREG,
        ST_LDALL,
        ST_RS_SETUP,
        ST_RS_LOW,
        ST_SETTLE
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       cs_n;
        logic       sclk;
        logic       ldreg_n;
        logic       ldall_n;
        logic       rst_n;
        logic       rstsel;
        logic       want_ldreg;
        logic       want_ldall;
    } seq_regs_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_wr_timer.sv
// Phase timer: loaded with (length - 1), counts down to zero and holds there.
module dac_wr_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/dac_wr_frame.sv
// Outgoing word register: its top bit drives the serial data pin directly.
module dac_wr_frame #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] load_word,
    input  logic          shift,
    output logic          sdo,
    output logic          last
);

    localparam int BW = $clog2(FW);

    logic [FW-1:0] word_d, word_q;
    logic [BW-1:0] left_d, left_q;

    always_comb begin
        word_d = word_q;
        left_d = left_q;
        if (load) begin
            word_d = load_word;
            left_d = BW'(FW - 1);
        end else if (shift) begin
            word_d = {word_q[FW-2:0], 1'b0};
            left_d = left_q - BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else begin
            word_q <= word_d;
            left_q <= left_d;
        end
    end

    assign sdo  = word_q[FW-1];
    assign last = (left_q == '0);

endmodule

// File: rtl/dac_host_writer.sv
module dac_host_writer
    import dac_wr_pkg::*;
#(
    parameter int CHAN_W   = 2,
    parameter int PAD_W    = 2,
    parameter int CODE_W   = 12,
    parameter int T_DS     = 7,
    parameter int T_DH     = 5,
    parameter int T_CH     = 8,
    parameter int T_CL     = 13,
    parameter int T_CSS    = 14,
    parameter int T_CSH    = 4,
    parameter int T_LD1    = 10,
    parameter int T_LD2    = 4,
    parameter int T_LDRW   = 12,
    parameter int T_LDDW   = 12,
    parameter int T_RSSH   = 7,
    parameter int T_RSTW   = 18,
    parameter int T_SETTLE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_clear,
    input  logic              req_mid,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_load_reg,
    input  logic              req_load_all,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdi,
    output logic              dac_ldreg_n,
    output logic              dac_ldall_n,
    output logic              dac_rst_n,
    output logic              dac_rstsel
);

    localparam int FW       = CHAN_W + PAD_W + CODE_W;
    // Phase lengths merge every limit that applies to the same interval.
    localparam int LO_CYC   = max2(T_CL, T_DS);
    localparam int LO_FIRST = max2(LO_CYC, max2(T_CSS, T_LD1));
    localparam int HI_CYC   = max2(T_CH, T_DH);
    localparam int HI_LAST  = max2(HI_CYC, max2(T_CSH, T_LD2));
    localparam int MAX_DUR  = max2(max2(max2(LO_FIRST, HI_LAST), max2(T_LDRW, T_LDDW)),
                                   max2(max2(T_RSSH, T_RSTW), T_SETTLE));
    localparam int TW       = $clog2(MAX_DUR + 1);

    localparam logic [TW-1:0] DUR_LO_FIRST = TW'(LO_FIRST - 1);
    localparam logic [TW-1:0] DUR_LO       = TW'(LO_CYC - 1);
    localparam logic [TW-1:0] DUR_HI       = TW'(HI_CYC - 1);
    localparam logic [TW-1:0] DUR_HI_LAST  = TW'(HI_LAST - 1);
    localparam logic [TW-1:0] DUR_LDRW     = TW'(T_LDRW - 1);
    localparam logic [TW-1:0] DUR_LDDW     = TW'(T_LDDW - 1);
    localparam logic [TW-1:0] DUR_RSSH     = TW'(T_RSSH - 1);
    localparam logic [TW-1:0] DUR_RSTW     = TW'(T_RSTW - 1);
    localparam logic [TW-1:0] DUR_SETTLE   = TW'((T_SETTLE > 0) ? T_SETTLE - 1 : 0);

    localparam seq_regs_t SEQ_RST = '{
        st:         ST_IDLE,
        cs_n:       1'b1,
        sclk:       1'b1,
        ldreg_n:    1'b1,
        ldall_n:    1'b1,
        rst_n:      1'b1,
        rstsel:     1'b0,
        want_ldreg: 1'b0,
        want_ldall: 1'b0
    };

    seq_regs_t     r_d, r_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          frm_load;
    logic          frm_shift;
    logic          frm_last;
    logic          frm_sdo;
    logic          seq_end;
    logic [FW-1:0] frm_word;

    assign frm_word = {req_chan, {PAD_W{1'b0}}, req_code};

    dac_wr_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dac_wr_frame #(.FW(FW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frm_load),
        .load_word (frm_word),
        .shift     (frm_shift),
        .sdo       (frm_sdo),
        .last      (frm_last)
    );

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        frm_load  = 1'b0;
        frm_shift = 1'b0;
        seq_end   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_clear) begin
                        r_d.rstsel = req_mid;
                        r_d.st     = ST_RS_SETUP;
                        tmr_val    = DUR_RSSH;
                    end else begin
                        frm_load       = 1'b1;
                        r_d.cs_n       = 1'b0;
                        r_d.sclk       = 1'b0;
                        r_d.want_ldreg = req_load_reg;
                        r_d.want_ldall = req_load_all;
                        r_d.st         = ST_SH_LO;
                        tmr_val        = DUR_LO_FIRST;
                    end
                end
            end
            ST_SH_LO: begin
                if (tmr_done) begin
                    r_d.sclk = 1'b1;
                    r_d.st   = ST_SH_HI;
                    tmr_load = 1'b1;
                    tmr_val  = frm_last ? DUR_HI_LAST : DUR_HI;
                end
            end
            ST_SH_HI: begin
                if (tmr_done) begin
                    if (frm_last) begin
                        r_d.cs_n = 1'b1;
                        if (r_q.want_ldreg) begin
                            r_d.ldreg_n = 1'b0;
                            r_d.st      = ST_LDREG;
                            tmr_load    = 1'b1;
                            tmr_val     = DUR_LDRW;
                        end else if (r_q.want_ldall) begin
                            r_d.ldall_n = 1'b0;
                            r_d.st      = ST_LDALL;
                            tmr_load    = 1'b1;
                            tmr_val     = DUR_LDDW;
                        end else begin
                            seq_end = 1'b1;
                        end
                    end else begin
                        r_d.sclk  = 1'b0;
                        frm_shift = 1'b1;
                        r_d.st    = ST_SH_LO;
                        tmr_load  = 1'b1;
                        tmr_val   = DUR_LO;
                    end
                end
            end
            ST_LDREG: begin
                if (tmr_done) begin
                    r_d.ldreg_n = 1'b1;
                    if (r_q.want_ldall) begin
                        r_d.ldall_n = 1'b0;
                        r_d.st      = ST_LDALL;
                        tmr_load    = 1'b1;
                        tmr_val     = DUR_LDDW;
                    end else begin
                        seq_end = 1'b1;
                    end
                end
            end
            ST_LDALL: begin
                if (tmr_done) begin
                    r_d.ldall_n = 1'b1;
                    seq_end     = 1'b1;
                end
            end
            ST_RS_SETUP: begin
                if (tmr_done) begin
                    r_d.rst_n = 1'b0;
                    r_d.st    = ST_RS_LOW;
                    tmr_load  = 1'b1;
                    tmr_val   = DUR_RSTW;
                end
            end
            ST_RS_LOW: begin
                if (tmr_done) begin
                    r_d.rst_n = 1'b1;
                    seq_end   = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (seq_end) begin
            if (T_SETTLE > 0) begin
                r_d.st   = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = DUR_SETTLE;
            end else begin
                r_d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SEQ_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign dac_cs_n    = r_q.cs_n;
    assign dac_sclk    = r_q.sclk;
    assign dac_sdi     = frm_sdo;
    assign dac_ldreg_n = r_q.ldreg_n;
    assign dac_ldall_n = r_q.ldall_n;
    assign dac_rst_n   = r_q.rst_n;
    assign dac_rstsel  = r_q.rstsel;

endmodule

// File: rtl/dac_host_writer_chk.sv
module dac_host_writer_chk
    import dac_wr_pkg::*;
#(
    parameter int T_DS   = 7,
    parameter int T_DH   = 5,
    parameter int T_CH   = 8,
    parameter int T_CL   = 13,
    parameter int T_CSS  = 14,
    parameter int T_CSH  = 4,
    parameter int T_LD1  = 10,
    parameter int T_LD2  = 4,
    parameter int T_LDRW = 12,
    parameter int T_LDDW = 12,
    parameter int T_RSSH = 7,
    parameter int T_RSTW = 18
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic dac_cs_n,
    input logic dac_sclk,
    input logic dac_sdi,
    input logic dac_ldreg_n,
    input logic dac_ldall_n,
    input logic dac_rst_n,
    input logic dac_rstsel
);

    localparam int CW = 8;
    localparam logic [CW-1:0] LO_MIN   = CW'(max2(T_CL, T_DS));
    localparam logic [CW-1:0] HI_MIN   = CW'(max2(T_CH, T_DH));
    localparam logic [CW-1:0] CSS_MIN  = CW'(T_CSS);
    localparam logic [CW-1:0] CSH_MIN  = CW'(T_CSH);
    localparam logic [CW-1:0] LD1_MIN  = CW'(T_LD1);
    localparam logic [CW-1:0] LD2_MIN  = CW'(T_LD2);
    localparam logic [CW-1:0] LDRW_MIN = CW'(T_LDRW);
    localparam logic [CW-1:0] LDDW_MIN = CW'(T_LDDW);
    localparam logic [CW-1:0] RSSH_MIN = CW'(T_RSSH);
    localparam logic [CW-1:0] RSTW_MIN = CW'(T_RSTW);

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
        return (c == '1) ? c : c + CW'(1);
    endfunction

    // Run lengths of pin levels, in cycles; they saturate and start saturated.
    logic [CW-1:0] sclk_lo_q, sclk_hi_q, cs_lo_q, ldreg_hi_q, ldreg_lo_q;
    logic [CW-1:0] ldall_lo_q, rst_lo_q, sel_run_q;
    logic          sel_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_lo_q  <= '1;
            sclk_hi_q  <= '1;
            cs_lo_q    <= '1;
            ldreg_hi_q <= '1;
            ldreg_lo_q <= '1;
            ldall_lo_q <= '1;
            rst_lo_q   <= '1;
            sel_run_q  <= '1;
            sel_prev_q <= 1'b0;
        end else begin
            sclk_lo_q  <= dac_sclk    ? '0 : bump(sclk_lo_q);
            sclk_hi_q  <= dac_sclk    ? bump(sclk_hi_q) : '0;
            cs_lo_q    <= dac_cs_n    ? '0 : bump(cs_lo_q);
            ldreg_hi_q <= dac_ldreg_n ? bump(ldreg_hi_q) : '0;
            ldreg_lo_q <= dac_ldreg_n ? '0 : bump(ldreg_lo_q);
            ldall_lo_q <= dac_ldall_n ? '0 : bump(ldall_lo_q);
            rst_lo_q   <= dac_rst_n   ? '0 : bump(rst_lo_q);
            sel_run_q  <= (dac_rstsel != sel_prev_q) ? CW'(1) : bump(sel_run_q);
            sel_prev_q <= dac_rstsel;
        end
    end

    assert_sclk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> sclk_lo_q >= LO_MIN);
    assert_sclk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk) |-> sclk_hi_q >= HI_MIN);
    assert_sdi_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_sdi) |-> $fell(dac_sclk));
    assert_cs_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dac_sclk) && !dac_cs_n) |-> cs_lo_q >= CSS_MIN);
    assert_cs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> (dac_sclk && sclk_hi_q >= CSH_MIN));
    assert_ldreg_high_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_cs_n |-> dac_ldreg_n);
    assert_ldreg_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> ldreg_hi_q >= LD1_MIN);
    assert_ldreg_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_ldreg_n) |-> (dac_sclk && sclk_hi_q >= LD2_MIN));
    assert_ldreg_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_ldreg_n) |-> ldreg_lo_q >= LDRW_MIN);
    assert_ldall_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_ldall_n) |-> (dac_ldreg_n && dac_cs_n));
    assert_ldall_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_ldall_n) |-> ldall_lo_q >= LDDW_MIN);
    assert_rstsel_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_rst_n) |-> sel_run_q >= RSSH_MIN);
    assert_rst_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_rst_n) |-> rst_lo_q >= RSTW_MIN);
    assert_rstsel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_rst_n && !$rose(dac_rst_n)) |-> $stable(dac_rstsel));
    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_idle_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dac_cs_n && dac_sclk && dac_ldreg_n && dac_ldall_n && dac_rst_n));

endmodule

bind dac_host_writer dac_host_writer_chk #(
    .T_DS   (T_DS),
    .T_DH   (T_DH),
    .T_CH   (T_CH),
    .T_CL   (T_CL),
    .T_CSS  (T_CSS),
    .T_CSH  (T_CSH),
    .T_LD1  (T_LD1),
    .T_LD2  (T_LD2),
    .T_LDRW (T_LDRW),
    .T_LDDW (T_LDDW),
    .T_RSSH (T_RSSH),
    .T_RSTW (T_RSTW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .dac_cs_n    (dac_cs_n),
    .dac_sclk    (dac_sclk),
    .dac_sdi     (dac_sdi),
    .dac_ldreg_n (dac_ldreg_n),
    .dac_ldall_n (dac_ldall_n),
    .dac_rst_n   (dac_rst_n),
    .dac_rstsel  (dac_rstsel)
);

// File: tb/dac_host_writer_tb.sv
`timescale 1ns/1ps
module dac_host_writer_tb;

    localparam int T_DS = 7, T_DH = 5, T_CH = 8, T_CL = 13, T_CSS = 14, T_CSH = 4;
    localparam int T_LD1 = 10, T_LD2 = 4, T_LDRW = 12, T_LDDW = 12;
    localparam int T_RSSH = 7, T_RSTW = 18, T_SETTLE = 3;
    localparam int LO_MIN = (T_CL > T_DS) ? T_CL : T_DS;
    localparam int HI_MIN = (T_CH > T_DH) ? T_CH : T_DH;
    localparam int NVEC = 12;

    // {clear, mid, chan[1:0], code[11:0], load_reg, load_all}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 2'd0, 12'h000, 1'b1, 1'b0},
        {1'b0, 1'b0, 2'd1, 12'hFFF, 1'b1, 1'b1},
        {1'b0, 1'b0, 2'd2, 12'hA5A, 1'b1, 1'b0},
        {1'b0, 1'b0, 2'd3, 12'h5A5, 1'b0, 1'b1},
        {1'b1, 1'b1, 2'd0, 12'h000, 1'b0, 1'b0},
        {1'b0, 1'b0, 2'd3, 12'h800, 1'b0, 1'b0},
        {1'b0, 1'b0, 2'd0, 12'h123, 1'b1, 1'b1},
        {1'b1, 1'b0, 2'd2, 12'hFFF, 1'b1, 1'b1},
        {1'b0, 1'b0, 2'd1, 12'hC3C, 1'b1, 1'b1},
        {1'b0, 1'b0, 2'd2, 12'h001, 1'b1, 1'b0},
        {1'b1, 1'b1, 2'd1, 12'h000, 1'b0, 1'b0},
        {1'b0, 1'b0, 2'd3, 12'hFFE, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_clear = 1'b0, req_mid = 1'b0;
    logic [1:0]  req_chan = '0;
    logic [11:0] req_code = '0;
    logic        req_load_reg = 1'b0, req_load_all = 1'b0;
    logic        req_ready;
    logic        dac_cs_n, dac_sclk, dac_sdi, dac_ldreg_n, dac_ldall_n, dac_rst_n, dac_rstsel;

    dac_host_writer #(
        .T_DS(T_DS), .T_DH(T_DH), .T_CH(T_CH), .T_CL(T_CL), .T_CSS(T_CSS), .T_CSH(T_CSH),
        .T_LD1(T_LD1), .T_LD2(T_LD2), .T_LDRW(T_LDRW), .T_LDDW(T_LDDW),
        .T_RSSH(T_RSSH), .T_RSTW(T_RSTW), .T_SETTLE(T_SETTLE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_clear(req_clear), .req_mid(req_mid), .req_chan(req_chan), .req_code(req_code),
        .req_load_reg(req_load_reg), .req_load_all(req_load_all),
        .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
        .dac_ldreg_n(dac_ldreg_n), .dac_ldall_n(dac_ldall_n),
        .dac_rst_n(dac_rst_n), .dac_rstsel(dac_rstsel)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pin observer: samples on the falling clock edge.
    logic        p_cs, p_sclk, p_sdi, p_ldreg, p_ldall, p_rst, p_sel;
    int          lo_run, hi_run, cs_lo_run, ldreg_hi_run, ldreg_lo_run, ldall_lo_run, rst_lo_run, sel_run;
    logic [15:0] shreg;
    int          nbits, n_ldreg, n_ldall, n_rst, idle_busy;
    logic        sel_at_fall;
    int          v2, v3, v4, v5, v6, v7;

    task automatic clear_obs();
        shreg = '0; nbits = 0; n_ldreg = 0; n_ldall = 0; n_rst = 0; idle_busy = 0;
        sel_at_fall = 1'b0;
        v2 = 0; v3 = 0; v4 = 0; v5 = 0; v6 = 0; v7 = 0;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            p_cs = 1'b1; p_sclk = 1'b1; p_sdi = dac_sdi; p_ldreg = 1'b1; p_ldall = 1'b1;
            p_rst = 1'b1; p_sel = dac_rstsel;
            lo_run = 1000; hi_run = 1000; cs_lo_run = 1000; ldreg_hi_run = 1000;
            ldreg_lo_run = 1000; ldall_lo_run = 1000; rst_lo_run = 1000; sel_run = 1000;
        end else begin
            if (!p_sclk && dac_sclk) begin
                if (!dac_cs_n) begin
                    shreg = {shreg[14:0], dac_sdi};
                    nbits++;
                end
                if (lo_run < LO_MIN) v2++;
                if (nbits == 1 && cs_lo_run < T_CSS) v3++;
                if (ldreg_hi_run < T_LD1 || !dac_ldreg_n) v4++;
            end
            if (p_sclk && !dac_sclk && hi_run < HI_MIN) v2++;
            if (dac_sdi != p_sdi && !(p_sclk && !dac_sclk)) v2++;
            if (!p_cs && dac_cs_n && (!dac_sclk || hi_run < T_CSH)) v3++;
            if (!dac_cs_n && !dac_ldreg_n) v4++;
            if (p_ldreg && !dac_ldreg_n) begin
                n_ldreg++;
                if (!dac_sclk || hi_run < T_LD2 || !dac_cs_n) v5++;
            end
            if (!p_ldreg && dac_ldreg_n && ldreg_lo_run < T_LDRW) v5++;
            if (p_ldall && !dac_ldall_n) begin
                n_ldall++;
                if (!dac_ldreg_n || !dac_cs_n) v6++;
            end
            if (!p_ldall && dac_ldall_n && ldall_lo_run < T_LDDW) v6++;
            if (p_rst && !dac_rst_n) begin
                n_rst++;
                sel_at_fall = dac_rstsel;
                if (sel_run < T_RSSH) v7++;
            end
            if (!p_rst && dac_rst_n && rst_lo_run < T_RSTW) v7++;
            if (!dac_rst_n && dac_rstsel != p_sel) v7++;
            if (!req_ready && dac_cs_n && dac_sclk && dac_ldreg_n && dac_ldall_n && dac_rst_n)
                idle_busy++;

            lo_run       = dac_sclk    ? 0 : lo_run + 1;
            hi_run       = dac_sclk    ? hi_run + 1 : 0;
            cs_lo_run    = dac_cs_n    ? 0 : cs_lo_run + 1;
            ldreg_hi_run = dac_ldreg_n ? ldreg_hi_run + 1 : 0;
            ldreg_lo_run = dac_ldreg_n ? 0 : ldreg_lo_run + 1;
            ldall_lo_run = dac_ldall_n ? 0 : ldall_lo_run + 1;
            rst_lo_run   = dac_rst_n   ? 0 : rst_lo_run + 1;
            sel_run      = (dac_rstsel != p_sel) ? 1 : sel_run + 1;
            p_cs = dac_cs_n; p_sclk = dac_sclk; p_sdi = dac_sdi; p_ldreg = dac_ldreg_n;
            p_ldall = dac_ldall_n; p_rst = dac_rst_n; p_sel = dac_rstsel;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check_idle_pins(input string tag);
        check_eq("R9", {tag, " ready"}, int'(req_ready), 1);
        check_eq("R9", {tag, " idle pins"},
                 int'({dac_cs_n, dac_sclk, dac_ldreg_n, dac_ldall_n, dac_rst_n}), 31);
    endtask

    task automatic offer(input logic [17:0] v);
        logic       clr, mid, lr, la;
        logic [1:0] ch;
        logic [11:0] code;
        {clr, mid, ch, code, lr, la} = v;
        while (!req_ready) step();
        clear_obs();
        req_clear = clr; req_mid = mid; req_chan = ch; req_code = code;
        req_load_reg = lr; req_load_all = la; req_valid = 1'b1;
        step();
        req_valid = 1'b0;
    endtask

    task automatic run_req(input logic [17:0] v);
        logic       clr, mid, lr, la;
        logic [1:0] ch;
        logic [11:0] code;
        {clr, mid, ch, code, lr, la} = v;
        offer(v);
        check_eq("R8", "ready after accept", int'(req_ready), 0);
        while (!req_ready) step();
        if (clr) begin
            check_eq("R7", "reset pulses", n_rst, 1);
            check_eq("R7", "reset level", int'(sel_at_fall), int'(mid));
            check_eq("R7", "no frame bits", nbits, 0);
            check_eq("R7", "reset timing errors", v7, 0);
            check_eq("R8", "settle cycles clear", idle_busy, T_RSSH + T_SETTLE);
        end else begin
            check_eq("R1", "bit count", nbits, 16);
            check_eq("R1", "channel field", int'(shreg[15:14]), int'(ch));
            check_eq("R1", "pad field", int'(shreg[13:12]), 0);
            check_eq("R1", "code field", int'(shreg[11:0]), int'(code));
            check_eq("R2", "clock/data errors", v2, 0);
            check_eq("R3", "chip select errors", v3, 0);
            check_eq("R4", "ldreg in frame errors", v4, 0);
            check_eq("R5", "ldreg pulses", n_ldreg, int'(lr));
            check_eq("R5", "ldreg timing errors", v5, 0);
            check_eq("R6", "ldall pulses", n_ldall, int'(la));
            check_eq("R6", "ldall order errors", v6, 0);
            check_eq("R7", "no reset on write", n_rst, 0);
            check_eq("R8", "settle cycles write", idle_busy, T_SETTLE);
        end
        check_idle_pins("after request");
    endtask

    initial begin
        clear_obs();
        repeat (4) step();
        check_eq("R9", "rstsel in reset", int'(dac_rstsel), 0);
        rst_n = 1'b1;
        step();
        check_idle_pins("after reset");
        check_eq("R9", "rstsel after reset", int'(dac_rstsel), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_req(VEC[i]);
        end

        // Directed: system reset in the middle of a frame (R9).
        offer({1'b0, 1'b0, 2'd2, 12'h3C3, 1'b1, 1'b1});
        repeat (40) step();
        check_eq("R9", "frame active before reset", int'(dac_cs_n), 0);
        rst_n = 1'b0;
        step();
        check_idle_pins("reset mid frame");
        check_eq("R9", "rstsel mid-frame reset", int'(dac_rstsel), 0);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check_idle_pins("release mid frame");

        // Directed: a frame right after recovery, then a zero-scale clear.
        run_req({1'b0, 1'b0, 2'd1, 12'h7FF, 1'b1, 1'b1});
        run_req({1'b1, 1'b0, 2'd0, 12'h000, 1'b0, 1'b0});

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule